// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master side of a two-wire management bus that talks to a PHY. It drives the management clock and the data line. The data line is bidirectional and is controlled through an output-enable. A host raises a one-cycle start request together with a read/write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then plays out one complete frame. `busy` stays high while the frame is on the wire. At the end the block pulses `done`, and for a read it presents the 16 bits collected from the PHY.

A frame is built from bit slots. Each slot is one MDC low half-period followed by one MDC high half-period, and each half lasts `HALF_DIV` system clocks. A driven bit changes at the start of the low half and stays constant through the rising edge.

The frame begins with an extended 40-slot preamble. For a read, the line is released after the register address. The last slot of every frame is an idle slot: the line is released and MDC still pulses. The host does not need to throttle its requests, because a request made during a frame is dropped.

Top module: `mdio_master`

## Requirements
- R1: During reset and right after it, `mdc_o` is 0, `mdio_oe_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: A start accepted while idle is followed by 40 slots in which `mdio_oe_o`=1 and `mdio_o`=1. The first slot begins in the cycle after the accepting edge.
- R3: After the preamble, the line carries the start pattern 0 then 1. The opcode follows: 1 then 0 when `rd_i`=1, and 0 then 1 when `rd_i`=0.
- R4: The next 10 slots carry `phy_addr_i` bit 4 down to bit 0, then `reg_addr_i` bit 4 down to bit 0. The line is driven throughout these slots.
- R5: For a write, the next two slots are driven as 1 then 0. Sixteen slots follow carrying `wr_data_i` bit 15 down to bit 0, all driven.
- R6: For a read, `mdio_oe_o` is 0 from the first slot after the register address to the end of the frame. There are two turnaround slots, then 16 data slots. In each data slot, `mdio_i` is sampled on the last system clock of the MDC low half. The first sample lands in bit 15 and the last in bit 0 of `rd_data_o`.
- R7: Every frame ends with one idle slot in which `mdio_oe_o`=0 while MDC still goes low then high. `done_o` is high for exactly one cycle, the first cycle after the frame, and `busy_o` is 0 in that cycle.
- R8: Each MDC low half and each high half lasts exactly `HALF_DIV` system clocks. A frame therefore takes 73 × 2 × `HALF_DIV` cycles. The data line changes only at the start of a low half.
- R9: A start request made while `busy_o`=1 has no effect: the frame in progress continues unchanged and no extra frame follows.
- R10: `rd_data_o` keeps its value from the `done_o` pulse until the data slots of the next read frame. Idle periods and write frames leave it unchanged.
- R11: `busy_o` is 1 from the cycle after an accepted start until the end of the idle slot. Whenever `busy_o` is 0, `mdc_o` and `mdio_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Frame request, taken when idle |
| rd_i | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wr_data_i | input | 16 | Data for a write frame |
| mdio_i | input | 1 | Sensed level of the data line |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Level driven onto the data line |
| mdio_oe_o | output | 1 | Data line output enable |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rd_data_o | output | 16 | Data collected by the last read |

## Verification
The bench builds the block with `HALF_DIV` = 2. A whole frame then takes only 292 cycles, so several frames fit into a short run. The bench covers write and read frames, all-zero and all-one data and addresses, and a request on the exact `done` cycle. It also covers a request that arrives mid-frame and a request held high across several cycles. With a half-period of two clocks, the timing window is visible: an off-by-one in the half-period counter or in the read sample point shifts the MDC edges or the captured bits.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the management frame master.
// Assumes clause-22 field widths.
package mdio_pkg;
    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    // start(2) + opcode(2) + PHY address + register address
    localparam int HDR_W  = 4 + PHY_W + REG_W;
    // turnaround(2) + data
    localparam int TAIL_W = 2 + DATA_W;

    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_e;
endpackage

// File: rtl/mdio_tick_gen.sv
// Half-period timer. While run is high, it counts system clocks and
// flags the last cycle of each MDC half-period.
// Assumes HALF_DIV >= 1. The counter is cleared while run is low.
module mdio_tick_gen #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;

    // Count clocks within the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == CNT_MAX) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign tick = run && (cnt == CNT_MAX);
endmodule

// File: rtl/mdio_bit_seq.sv
// Frame sequencer. It steps through the slots of a frame; each slot is
// a low half then a high half. It raises busy and pulses done after
// the last slot.
// Assumes tick marks the last clock of a half-period.
module mdio_bit_seq
    import mdio_pkg::*;
#(
    parameter int TOTAL_SLOTS = 73,
    parameter int SLOT_W      = $clog2(TOTAL_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              tick,
    output logic              busy,
    output logic              done,
    output half_e             half,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(TOTAL_SLOTS - 1);

    // Advance the half and slot position, and end the frame after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            half <= HALF_LOW;
            slot <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
                half <= HALF_LOW;
                slot <= '0;
            end else if (busy && tick) begin
                if (half == HALF_LOW) begin
                    half <= HALF_HIGH;
                end else if (slot == LAST_SLOT) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    half <= HALF_LOW;
                    slot <= '0;
                end else begin
                    half <= HALF_LOW;
                    slot <= slot + SLOT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/mdio_line_drv.sv
// Data line driver. It captures the request on acceptance. It then
// produces the level and output enable for each slot: preamble, start,
// opcode, addresses, and for writes the turnaround and data.
// Assumes slot is stable for a whole slot and changes only while MDC is low.
module mdio_line_drv
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 40,
    parameter int SLOT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              rd_i,
    input  logic [PHY_W-1:0]  phy_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [DATA_W-1:0] wd_i,
    input  logic              busy,
    input  logic [SLOT_W-1:0] slot,
    output logic              rd_q,
    output logic              mdio_o,
    output logic              oe_o
);
    localparam int HDR_END  = PRE_LEN + HDR_W;
    localparam int DATA_END = HDR_END + TAIL_W;

    logic [PHY_W-1:0]  phy_q;
    logic [REG_W-1:0]  reg_q;
    logic [DATA_W-1:0] wd_q;
    logic [HDR_W-1:0]  hdr;
    logic [TAIL_W-1:0] tail;
    logic [HDR_W-1:0]  hdr_sh;
    logic [TAIL_W-1:0] tail_sh;
    logic              bit_v;
    int                s;

    // Hold the request fields for the duration of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            phy_q <= '0;
            reg_q <= '0;
            wd_q  <= '0;
        end else if (accept) begin
            rd_q  <= rd_i;
            phy_q <= phy_i;
            reg_q <= reg_i;
            wd_q  <= wd_i;
        end
    end

    assign hdr  = {2'b01, (rd_q ? 2'b10 : 2'b01), phy_q, reg_q};
    assign tail = {2'b10, wd_q};

    // Select the bit and the enable for the current slot.
    always_comb begin
        s       = int'(slot);
        hdr_sh  = hdr << (s - PRE_LEN);
        tail_sh = tail << (s - HDR_END);
        bit_v   = 1'b0;
        oe_o    = 1'b0;
        if (busy) begin
            if (s < PRE_LEN) begin
                bit_v = 1'b1;
                oe_o  = 1'b1;
            end else if (s < HDR_END) begin
                bit_v = hdr_sh[HDR_W-1];
                oe_o  = 1'b1;
            end else if (s < DATA_END && !rd_q) begin
                bit_v = tail_sh[TAIL_W-1];
                oe_o  = 1'b1;
            end
        end
        mdio_o = oe_o && bit_v;
    end
endmodule

// File: rtl/mdio_rx_shift.sv
// Read data collector. On each enabled clock it shifts the sensed line
// level in at the least significant end. It holds its value otherwise.
// Assumes the enable marks one clock per data bit, most significant bit first.
module mdio_rx_shift
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [DATA_W-1:0] data
);
    // Shift in one bit per enabled clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (shift_en) begin
            data <= {data[DATA_W-2:0], din};
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Management frame master top. It accepts a request when idle, times
// the MDC half-periods, and plays out one frame of 40 + 33 slots.
// Assumes: synchronous active-low reset. The default HALF_DIV = 20
// keeps MDC at or below 2.5 MHz for a system clock up to 100 MHz.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 20,
    parameter int PRE_LEN  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [PHY_W-1:0]  phy_addr_i,
    input  logic [REG_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              mdio_i,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int TOTAL_SLOTS = PRE_LEN + HDR_W + TAIL_W + 1;
    localparam int SLOT_W      = $clog2(TOTAL_SLOTS);
    localparam logic [SLOT_W-1:0] RX_FIRST = SLOT_W'(PRE_LEN + HDR_W + 2);
    localparam logic [SLOT_W-1:0] RX_END   = SLOT_W'(PRE_LEN + HDR_W + TAIL_W);

    logic              accept;
    logic              tick;
    logic              busy;
    logic              done;
    half_e             half;
    logic [SLOT_W-1:0] slot;
    logic              rd_q;
    logic              sample;

    assign accept = start_i && !busy;

    mdio_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    mdio_bit_seq #(.TOTAL_SLOTS(TOTAL_SLOTS), .SLOT_W(SLOT_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .tick   (tick),
        .busy   (busy),
        .done   (done),
        .half   (half),
        .slot   (slot)
    );

    mdio_line_drv #(.PRE_LEN(PRE_LEN), .SLOT_W(SLOT_W)) u_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .rd_i   (rd_i),
        .phy_i  (phy_addr_i),
        .reg_i  (reg_addr_i),
        .wd_i   (wr_data_i),
        .busy   (busy),
        .slot   (slot),
        .rd_q   (rd_q),
        .mdio_o (mdio_o),
        .oe_o   (mdio_oe_o)
    );

    // Sample on the last clock of the low half of each read data slot.
    assign sample = busy && rd_q && tick && (half == HALF_LOW)
                    && (slot >= RX_FIRST) && (slot < RX_END);

    mdio_rx_shift u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample),
        .din      (mdio_i),
        .data     (rd_data_o)
    );

    assign mdc_o  = busy && (half == HALF_HIGH);
    assign busy_o = busy;
    assign done_o = done;
endmodule

// File: rtl/mdio_master_chk.sv
// Port-level checker for the management frame master. It is bound to
// every instance of the top module.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        mdc_o,
    input logic        mdio_o,
    input logic        mdio_oe_o,
    input logic        busy_o,
    input logic        done_o,
    input logic [15:0] rd_data_o
);
    // R1: the cycle after a reset edge is idle.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!mdc_o && !mdio_oe_o && !busy_o && !done_o));

    // R11: no clock and no drive while idle.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && !mdio_oe_o));

    // R8: a driven level changes only while MDC is low.
    assert_change_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe_o && $past(mdio_oe_o) && (mdio_o != $past(mdio_o))) |-> !mdc_o);

    // R7: done falls in the first idle cycle after a frame.
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R7: done lasts one cycle.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: a request during a frame does not restart or end it.
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && mdio_oe_o) |=> busy_o);

    // R10: read data holds while idle.
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> $stable(rd_data_o));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rd_data_o (rd_data_o)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;
    localparam int PRE  = 40;

    typedef struct {
        bit          busy, done, mdc, oe, mdio, mdi, chk_rd;
        logic [15:0] rdv;
        string       tag;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        mdio_i = 1'b1;
    logic        mdc_o, mdio_o, mdio_oe_o, busy_o, done_o;
    logic [15:0] rd_data_o;

    ent_t        q[$];
    int          vectors = 0;
    int          errors = 0;
    bit          finished = 0;
    logic [15:0] exp_rd = '0;
    string       idle_tag = "R1";
    logic [15:0] reply = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.HALF_DIV(HALF), .PRE_LEN(PRE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i),
        .mdio_i(mdio_i), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
        .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o)
    );

    task automatic cmp(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Queue the expected per-cycle line state of one frame from the requirements.
    task automatic push_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                              input logic [15:0] wd, input logic [15:0] rep);
        bit [13:0] hdr;
        bit [17:0] tail;
        hdr  = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
        tail = {2'b10, wd};
        for (int s = 0; s < PRE + 33; s++) begin
            ent_t e;
            e.busy = 1; e.done = 0; e.chk_rd = !rd; e.rdv = exp_rd; e.mdi = 1;
            if (s < PRE) begin
                e.oe = 1; e.mdio = 1; e.tag = "R2";
            end else if (s < PRE + 4) begin
                e.oe = 1; e.mdio = hdr[13 - (s - PRE)]; e.tag = "R3";
            end else if (s < PRE + 14) begin
                e.oe = 1; e.mdio = hdr[13 - (s - PRE)]; e.tag = "R4";
            end else if (s < PRE + 32) begin
                e.oe = !rd; e.mdio = rd ? 1'b0 : tail[17 - (s - PRE - 14)];
                e.tag = rd ? "R6" : "R5";
                if (rd && s >= PRE + 16) e.mdi = rep[15 - (s - PRE - 16)];
            end else begin
                e.oe = 0; e.mdio = 0; e.tag = "R7";
            end
            for (int h = 0; h < 2; h++) begin
                for (int c = 0; c < HALF; c++) begin
                    e.mdc = (h == 1);
                    q.push_back(e);
                end
            end
        end
        begin
            ent_t d;
            d.busy = 0; d.done = 1; d.mdc = 0; d.oe = 0; d.mdio = 0; d.mdi = 1;
            d.chk_rd = 1; d.rdv = rd ? rep : exp_rd; d.tag = rd ? "R6" : "R7";
            q.push_back(d);
        end
    endtask

    // One clock: compare the outputs with the model, then drive the next inputs.
    task automatic cycle(input bit st, input bit rd, input logic [4:0] pa,
                         input logic [4:0] ra, input logic [15:0] wd);
        @(negedge clk);
        vectors++;
        if (q.size() == 0) begin
            cmp(idle_tag, "busy", 16'(busy_o), 16'd0);
            cmp(idle_tag, "done", 16'(done_o), 16'd0);
            cmp(idle_tag, "mdc", 16'(mdc_o), 16'd0);
            cmp(idle_tag, "oe", 16'(mdio_oe_o), 16'd0);
            if (rst_n) cmp("R10", "rd_data idle", rd_data_o, exp_rd);
            mdio_i = 1'b1;
        end else begin
            ent_t e;
            e = q.pop_front();
            cmp("R11", "busy", 16'(busy_o), 16'(e.busy));
            cmp("R7", "done", 16'(done_o), 16'(e.done));
            cmp("R8", "mdc", 16'(mdc_o), 16'(e.mdc));
            cmp(e.tag, "oe", 16'(mdio_oe_o), 16'(e.oe));
            if (e.oe) cmp(e.tag, "mdio", 16'(mdio_o), 16'(e.mdio));
            if (e.chk_rd) cmp(e.done ? e.tag : "R10", "rd_data", rd_data_o, e.rdv);
            if (e.done) exp_rd = e.rdv;
            mdio_i = e.mdi;
        end
        start_i = st; rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wr_data_i = wd;
        if (st && q.size() == 0 && rst_n) push_frame(rd, pa, ra, wd, reply);
    endtask

    task automatic drain();
        while (q.size() > 0) cycle(0, 0, '0, '0, '0);
        repeat (3) cycle(0, 0, '0, '0, '0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R1: idle during reset and after release
        repeat (3) cycle(0, 0, '0, '0, '0);
        rst_n = 1'b1;
        repeat (3) cycle(0, 0, '0, '0, '0);
        idle_tag = "R11";

        // R5 write frame with mixed addresses and data
        cycle(1, 0, 5'h1F, 5'h00, 16'hA5C3);
        drain();

        // R6 read frame
        reply = 16'h8001;
        cycle(1, 1, 5'h01, 5'h1E, 16'hFFFF);
        drain();

        // R9: request in mid-frame is ignored
        reply = 16'h7FFE;
        cycle(1, 1, 5'h0A, 5'h15, 16'h0000);
        repeat (10) cycle(0, 0, '0, '0, '0);
        cycle(1, 0, 5'h1F, 5'h1F, 16'h1234);
        // R7: back-to-back request on the done cycle
        while (q.size() > 1) cycle(0, 0, '0, '0, '0);
        cycle(1, 0, 5'h00, 5'h00, 16'h0000);
        drain();

        // R10: write with all ones, request held high for several cycles
        cycle(1, 0, 5'h15, 5'h0A, 16'hFFFF);
        repeat (3) cycle(1, 1, 5'h03, 5'h03, 16'h0F0F);
        drain();

        // R6 second read pattern
        reply = 16'h5A5A;
        cycle(1, 1, 5'h1F, 5'h1F, 16'h0000);
        drain();
        finish_run();
    end
endmodule